// File: doc/BRIEF.md
# Key-Code Command Decoder

This block sits behind a register write port and watches one address, the key register. Most values written there do nothing. A few 16-bit magic values set off actions: a guarded software reset, a timed calibration memory refresh, a watchdog restart and the start of a single ADC conversion. Software writes a value to the key address. It then either sees a pulse on the matching output or polls the refresh-busy bit until it clears.

The software reset needs two key writes in a row, an arming value and then a firing value. Any other key write between them cancels the arming. A refresh command loads a down-counter from a programmable length. The busy bit stays high while the counter is non-zero. A new refresh command reloads the counter, even if a refresh is already running.

Top module: `key_command_decoder`

## Requirements
- R1: Only a cycle with `wr_en` high and `wr_addr` equal to the key address (default 0x08) is a key write. A write to any other address changes no output and leaves a pending arming in place.
- R2: A key write of 0x15FA arms the reset. A later key write of 0xAF51 while armed drives `soft_reset` high for one cycle, in the cycle after that write. Idle cycles between the two writes do not cancel the arming.
- R3: A key write of any value other than 0xAF51 or 0x15FA while armed disarms the reset. A key write of 0xAF51 when not armed has no effect. Repeating 0x15FA keeps the reset armed.
- R4: `soft_reset` is never high for two cycles in a row. When it fires, the arming clears and `refresh_busy` drops in the same cycle.
- R5: A key write of 0xFCBA raises `refresh_busy` in the next cycle. The bit stays high for exactly `refresh_len` cycles, or for one cycle when `refresh_len` is 0.
- R6: A refresh command that arrives while `refresh_busy` is high restarts the full count from the moment of that command.
- R7: A key write of 0x0D06 drives `wdt_kick` high for exactly one cycle, in the next cycle.
- R8: A key write of 0x1ADC drives `adc_start` high for exactly one cycle, in the next cycle.
- R9: A key write of any other value changes no output. At most one of the three pulses is high in any cycle.
- R10: While `rst_n` is low, and in the first cycle after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| refresh_len | input | CNT_W | Refresh duration in cycles (0 treated as 1) |
| soft_reset | output | 1 | One-cycle software reset pulse |
| refresh_busy | output | 1 | High while a calibration refresh is pending |
| wdt_kick | output | 1 | One-cycle watchdog restart pulse |
| adc_start | output | 1 | One-cycle ADC conversion start pulse |

## Verification
The three pulses come from registers, so each one is due in the first cycle after the clock edge that takes the write. The bench drives every write for one cycle starting at a falling edge, and samples at the next falling edge, which is exactly that cycle. `refresh_busy` also rises in that cycle. The bench counts how many falling-edge samples show busy high and compares the count with the programmed length, both for a single command and for a command that arrives mid-refresh. For the reset pulse, the bench checks the sample after the firing write and also the sample one cycle later, which shows that the pulse lasts exactly one cycle.

// File: rtl/key_command_decoder.sv
module key_command_decoder #(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 16,
  parameter int KEY_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [CNT_W-1:0]  refresh_len,
  output logic              soft_reset,
  output logic              refresh_busy,
  output logic              wdt_kick,
  output logic              adc_start
);
  localparam logic [15:0] CODE_ARM     = 16'h15FA;
  localparam logic [15:0] CODE_FIRE    = 16'hAF51;
  localparam logic [15:0] CODE_REFRESH = 16'hFCBA;
  localparam logic [15:0] CODE_WDT     = 16'h0D06;
  localparam logic [15:0] CODE_ADC     = 16'h1ADC;
  localparam logic [ADDR_W-1:0] KEY_SEL = ADDR_W'(KEY_ADDR);
  localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

  logic             armed;
  logic [CNT_W-1:0] busy_cnt;

  wire key_wr   = wr_en && (wr_addr == KEY_SEL);
  wire hit_arm  = key_wr && (wr_data == CODE_ARM);
  wire hit_fire = key_wr && (wr_data == CODE_FIRE) && armed;
  wire hit_ref  = key_wr && (wr_data == CODE_REFRESH);
  wire hit_wdt  = key_wr && (wr_data == CODE_WDT);
  wire hit_adc  = key_wr && (wr_data == CODE_ADC);

  wire [CNT_W-1:0] load_len = (refresh_len == '0) ? ONE : refresh_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      soft_reset <= 1'b0;
      wdt_kick   <= 1'b0;
      adc_start  <= 1'b0;
      busy_cnt   <= '0;
    end else begin
      if (key_wr) armed <= hit_arm;
      soft_reset <= hit_fire;
      wdt_kick   <= hit_wdt;
      adc_start  <= hit_adc;
      if (hit_fire)            busy_cnt <= '0;
      else if (hit_ref)        busy_cnt <= load_len;
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - ONE;
    end
  end

  assign refresh_busy = (busy_cnt != '0);

  assert_other_addr_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != KEY_SEL) |=> (!soft_reset && !wdt_kick && !adc_start));

  assert_fire_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> ($past(armed) && $past(wr_en) && $past(wr_data) == CODE_FIRE));

  assert_reset_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);

  assert_reset_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> (!refresh_busy && !armed));

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_busy) |-> ($past(wr_en) && $past(wr_addr) == KEY_SEL
                             && $past(wr_data) == CODE_REFRESH));

  assert_wdt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |-> ($past(wr_en) && $past(wr_addr) == KEY_SEL && $past(wr_data) == CODE_WDT));

  assert_adc_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(wr_en) && $past(wr_addr) == KEY_SEL && $past(wr_data) == CODE_ADC));

  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_reset, wdt_kick, adc_start}));
endmodule

// File: tb/test_key_command_decoder.sv
module test_key_command_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] refresh_len = 16'd1;
  logic        soft_reset, refresh_busy, wdt_kick, adc_start;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  key_command_decoder i_key_command_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .refresh_len(refresh_len),
    .soft_reset(soft_reset), .refresh_busy(refresh_busy),
    .wdt_kick(wdt_kick), .adc_start(adc_start)
  );

  // {addr, data, reset, wdt, adc, busy}; refresh_len = 1
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {5'h08, 16'h1ADC, 4'b0010},  // R8
    {5'h08, 16'h0D06, 4'b0100},  // R7
    {5'h08, 16'hFCBA, 4'b0001},  // R5
    {5'h08, 16'h15FA, 4'b0000},  // R2 arm
    {5'h08, 16'hAF51, 4'b1000},  // R2 fire
    {5'h08, 16'hAF51, 4'b0000},  // R3 not armed
    {5'h08, 16'h15FA, 4'b0000},
    {5'h08, 16'h1234, 4'b0000},  // R3 disarm
    {5'h08, 16'hAF51, 4'b0000},  // R3
    {5'h08, 16'h15FA, 4'b0000},
    {5'h09, 16'hAF51, 4'b0000},  // R1 other address
    {5'h08, 16'hAF51, 4'b1000},  // R1 arming kept
    {5'h08, 16'h15FA, 4'b0000},
    {5'h08, 16'h15FA, 4'b0000},  // R3 re-arm
    {5'h08, 16'hAF51, 4'b1000},
    {5'h07, 16'h1ADC, 4'b0000},  // R1
    {5'h08, 16'h0000, 4'b0000}   // R9
  };

  function automatic logic [3:0] outs();
    return {soft_reset, wdt_kick, adc_start, refresh_busy};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (refresh_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R10 outputs in reset", 16'(outs()), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 outputs after reset", 16'(outs()), 16'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][24:20], VEC[i][19:4]);
      check($sformatf("R1-table vector %0d (R2 R3 R5 R7 R8 R9)", i), 16'(outs()), 16'(VEC[i][3:0]));
      @(negedge clk);
      check($sformatf("R4 pulse cleared after vector %0d", i), 16'({soft_reset, wdt_kick, adc_start}), 16'h0);
    end

    refresh_len = 16'd5;
    do_write(5'h08, 16'hFCBA);
    count_busy(n);
    check("R5 busy length 5", 16'(n), 16'd5);

    refresh_len = 16'd0;
    do_write(5'h08, 16'hFCBA);
    count_busy(n);
    check("R5 busy length for zero", 16'(n), 16'd1);

    refresh_len = 16'd4;
    do_write(5'h08, 16'hFCBA);
    repeat (2) @(negedge clk);
    check("R6 busy mid refresh", 16'(refresh_busy), 16'd1);
    do_write(5'h08, 16'hFCBA);
    count_busy(n);
    check("R6 restarted length", 16'(n), 16'd4);

    refresh_len = 16'd20;
    do_write(5'h08, 16'hFCBA);
    do_write(5'h08, 16'h15FA);
    do_write(5'h08, 16'hAF51);
    check("R4 reset pulse and busy cleared", 16'(outs()), 16'b1000);
    @(negedge clk);
    check("R4 reset pulse one cycle", 16'(outs()), 16'h0);
    do_write(5'h08, 16'hAF51);
    check("R4 arming cleared by reset", 16'(outs()), 16'h0);

    do_write(5'h08, 16'h0D06);
    check("R7 kick", 16'(wdt_kick), 16'd1);
    @(negedge clk);
    check("R7 kick one cycle", 16'(wdt_kick), 16'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule